// File: doc/BRIEF.md
# Serial Equalizer Command Receiver

This block is the control logic of a stereo fourteen-band graphic equalizer. It takes 8-bit command words from a three-wire serial port with a shift clock, a data line and a latch strobe. The command clock and the strobe are asynchronous to the system clock, so all three lines pass through synchronizers. Edges are detected in the system clock domain. Bits enter the shift register on each rising edge of the command clock, lowest bit first. The completed word takes effect on the rising edge of the strobe.

A word whose top bit is set selects a band and sets the range of each channel. The selection is remembered, so any number of gain words can follow it without a new selection. A word whose top bit is clear is a gain word. Its six low bits drive six resistor taps directly: the 1, 2, 3, 4, 5 and 9 dB taps. Bit 6 chooses boost or cut. For every band the block drives a boost-tap vector and a cut-tap vector. The range outputs select half range (±6 dB) when they are high.

Top module: `eq_cmd_rx`

## Requirements
- R1: After reset, every boost and cut tap vector is zero (all bands flat), no band is selected, and range_half_a and range_half_b are low (±12 dB).
- R2: On each rising edge of ser_clk the current ser_data bit is shifted in. The first bit of a word lands in bit 0 and the eighth bit lands in bit 7.
- R3: Outputs change only after a rising edge of ser_strobe. Shifting bits without a strobe leaves every output unchanged, and a later strobe applies the word held in the shift register.
- R4: A word with bit 7 = 1 loads range_half_a from bit 5 and range_half_b from bit 4, and takes bits 3..0 as the selected band code. Bit 6 has no effect.
- R5: A word with bit 7 = 0 writes the selected band only. Band code k (1..14) owns bits [(k-1)*6 +: 6] of both tap vectors, and codes 1..7 are channel A. Bit 6 = 1 puts bits 5..0 on the boost vector and zeroes the cut vector. Bit 6 = 0 does the reverse.
- R6: A gain word whose bits 5..0 are zero leaves the band flat, with both vectors zero, whatever bit 6 holds. The patterns for 1 to 12 dB (bits 5..0) are 100000, 010000, 001000, 000100, 000010, 010010, 101010, 010110, 000001, 101001, 101101 and 101111.
- R7: When the selected band code is 0 or 15, gain words leave every tap vector unchanged.
- R8: A gain word does not change the band selection, so later gain words go to the same band.
- R9: For every band, at most one of its boost and cut vectors is non-zero.
- R10: A band-select word leaves every tap vector unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than ser_clk |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Asynchronous serial shift clock |
| ser_data | input | 1 | Serial data, sampled on rising ser_clk |
| ser_strobe | input | 1 | Asynchronous latch strobe; its rising edge applies the word |
| boost_en | output | 84 | Boost tap enables, 6 per band, band 1 in bits 5..0 |
| cut_en | output | 84 | Cut tap enables, same layout as boost_en |
| range_half_a | output | 1 | Channel A in ±6 dB range when high |
| range_half_b | output | 1 | Channel B in ±6 dB range when high |

## Verification
The assertions assume that ser_clk, ser_data and ser_strobe each stay stable for several system clocks around every edge. Under that assumption a synchronized clock edge always sees settled data, and a strobe never coincides with a shift. The stimulus changes ser_data only while ser_clk is low and holds every level for four system clocks. It also raises the strobe only after the eighth clock has fallen. The sweep covers every band, every gain step, both boost and cut, and both range settings.

// File: rtl/eqrx_pkg.sv
package eqrx_pkg;
    localparam int NUM_BANDS   = 14;
    localparam int TAP_W       = 6;
    localparam int WORD_W      = TAP_W + 2;
    localparam int CODE_W      = 4;
    localparam int SYNC_STAGES = 2;
    localparam int VEC_W       = NUM_BANDS * TAP_W;

    localparam int KIND_BIT  = WORD_W - 1;
    localparam int BOOST_BIT = WORD_W - 2;
    localparam int RNG_A_BIT = 5;
    localparam int RNG_B_BIT = 4;

    typedef enum logic {
        WK_GAIN = 1'b0,
        WK_BAND = 1'b1
    } word_kind_t;

    typedef struct packed {
        logic             boost;
        logic [TAP_W-1:0] taps;
    } band_cfg_t;

    function automatic logic code_valid(input logic [CODE_W-1:0] c);
        return (c != '0) && (int'(c) <= NUM_BANDS);
    endfunction

    function automatic word_kind_t kind_of(input logic [WORD_W-1:0] w);
        return word_kind_t'(w[KIND_BIT]);
    endfunction
endpackage

// File: rtl/eqrx_sync.sv
module eqrx_sync #(
    parameter int STAGES = eqrx_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= 1'b0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/eqrx_shift.sv
module eqrx_shift #(
    parameter int W = eqrx_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst)           word <= '0;
        else if (shift_en) word <= {din, word[W-1:1]};
    end

    // the newest bit always enters at the top, so the first bit ends in bit 0
    p_shift_in_r2: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (word[W-1] == $past(din)) && (word[W-2:0] == $past(word[W-1:1])));
    p_shift_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(word));
endmodule

// File: rtl/eqrx_bank.sv
module eqrx_bank
    import eqrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [WORD_W-1:0] word,
    output logic [VEC_W-1:0]  boost_en,
    output logic [VEC_W-1:0]  cut_en,
    output logic              range_half_a,
    output logic              range_half_b
);
    band_cfg_t         cfg [NUM_BANDS];
    logic [CODE_W-1:0] sel_code;
    logic              is_band, is_gain, hit_valid;

    always_comb begin
        is_band   = commit && (kind_of(word) == WK_BAND);
        is_gain   = commit && (kind_of(word) == WK_GAIN);
        hit_valid = is_gain && code_valid(sel_code);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_code     <= '0;
            range_half_a <= 1'b0;
            range_half_b <= 1'b0;
        end else if (is_band) begin
            sel_code     <= word[CODE_W-1:0];
            range_half_a <= word[RNG_A_BIT];
            range_half_b <= word[RNG_B_BIT];
        end
    end

    generate
        for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
            logic wr_here;
            assign wr_here = hit_valid && (int'(sel_code) == b + 1);

            always_ff @(posedge clk) begin
                if (rst) begin
                    cfg[b] <= '0;
                end else if (wr_here) begin
                    cfg[b].taps  <= word[TAP_W-1:0];
                    cfg[b].boost <= word[BOOST_BIT];
                end
            end

            assign boost_en[b*TAP_W +: TAP_W] = cfg[b].boost ? cfg[b].taps : '0;
            assign cut_en[b*TAP_W +: TAP_W]   = cfg[b].boost ? '0 : cfg[b].taps;

            p_one_side_r9: assert property (@(posedge clk) disable iff (rst)
                !((|boost_en[b*TAP_W +: TAP_W]) && (|cut_en[b*TAP_W +: TAP_W])));
        end
    endgenerate

    p_range_load_r4: assert property (@(posedge clk) disable iff (rst)
        is_band |=> (range_half_a == $past(word[RNG_A_BIT]))
                 && (range_half_b == $past(word[RNG_B_BIT])));
    p_band_word_keeps_gain_r10: assert property (@(posedge clk) disable iff (rst)
        is_band |=> $stable(boost_en) && $stable(cut_en));
    p_gain_keeps_sel_r8: assert property (@(posedge clk) disable iff (rst)
        is_gain |=> $stable(sel_code) && $stable(range_half_a) && $stable(range_half_b));
    p_no_sel_no_write_r7: assert property (@(posedge clk) disable iff (rst)
        (is_gain && !code_valid(sel_code)) |=> $stable(boost_en) && $stable(cut_en));
endmodule

// File: rtl/eq_cmd_rx.sv
module eq_cmd_rx
    import eqrx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             ser_strobe,
    output logic [VEC_W-1:0] boost_en,
    output logic [VEC_W-1:0] cut_en,
    output logic             range_half_a,
    output logic             range_half_b
);
    logic              sclk_lvl, sclk_rise;
    logic              sdat_lvl, sdat_rise;
    logic              stb_lvl, stb_rise;
    logic [WORD_W-1:0] shreg;

    eqrx_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
        .clk(clk), .rst(rst), .async_in(ser_clk), .level(sclk_lvl), .rise(sclk_rise));
    eqrx_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
        .clk(clk), .rst(rst), .async_in(ser_data), .level(sdat_lvl), .rise(sdat_rise));
    eqrx_sync #(.STAGES(SYNC_STAGES)) u_sync_stb (
        .clk(clk), .rst(rst), .async_in(ser_strobe), .level(stb_lvl), .rise(stb_rise));

    eqrx_shift #(.W(WORD_W)) u_shift (
        .clk(clk), .rst(rst), .shift_en(sclk_rise), .din(sdat_lvl), .word(shreg));

    eqrx_bank u_bank (
        .clk(clk), .rst(rst), .commit(stb_rise), .word(shreg),
        .boost_en(boost_en), .cut_en(cut_en),
        .range_half_a(range_half_a), .range_half_b(range_half_b));

    p_outputs_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !stb_rise |=> $stable(boost_en) && $stable(cut_en)
                   && $stable(range_half_a) && $stable(range_half_b));
    p_reset_flat_r1: assert property (@(posedge clk)
        $past(rst) |-> (boost_en == '0) && (cut_en == '0) && !range_half_a && !range_half_b);
endmodule

// File: tb/eq_cmd_rx_tb.sv
module eq_cmd_rx_tb;
    localparam int NB = 14;
    localparam int TW = 6;
    localparam int VW = NB * TW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_strobe = 1'b0;
    logic [VW-1:0] boost_en, cut_en;
    logic range_half_a, range_half_b;

    logic [VW-1:0] exp_boost = '0, exp_cut = '0;
    logic exp_ra = 1'b0, exp_rb = 1'b0;
    logic [3:0] exp_code = 4'd0;
    int n_checks = 0, n_fail = 0;

    always #10 clk = ~clk;

    eq_cmd_rx u_dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_strobe(ser_strobe), .boost_en(boost_en), .cut_en(cut_en),
        .range_half_a(range_half_a), .range_half_b(range_half_b));

    function automatic logic [5:0] gain_pat(input int db);
        case (db)
            1: return 6'b100000;  2: return 6'b010000;  3: return 6'b001000;
            4: return 6'b000100;  5: return 6'b000010;  6: return 6'b010010;
            7: return 6'b101010;  8: return 6'b010110;  9: return 6'b000001;
            10: return 6'b101001; 11: return 6'b101101; 12: return 6'b101111;
            default: return 6'b000000;
        endcase
    endfunction

    task automatic model(input logic [7:0] w);
        int idx;
        if (w[7]) begin
            exp_ra = w[5]; exp_rb = w[4]; exp_code = w[3:0];
        end else if (exp_code >= 1 && exp_code <= 14) begin
            idx = int'(exp_code) - 1;
            exp_boost[idx*TW +: TW] = w[6] ? w[5:0] : 6'b0;
            exp_cut[idx*TW +: TW]   = w[6] ? 6'b0 : w[5:0];
        end
    endtask

    task automatic check(input string req);
        n_checks++;
        if (boost_en !== exp_boost || cut_en !== exp_cut ||
            range_half_a !== exp_ra || range_half_b !== exp_rb) begin
            n_fail++;
            $display("FAIL %s: boost=%h cut=%h ra=%b rb=%b expected boost=%h cut=%h ra=%b rb=%b",
                     req, boost_en, cut_en, range_half_a, range_half_b,
                     exp_boost, exp_cut, exp_ra, exp_rb);
        end
    endtask

    task automatic shift_word(input logic [7:0] w);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); ser_data = w[i];
            repeat (4) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_strobe();
        @(negedge clk); ser_strobe = 1'b1;
        repeat (4) @(negedge clk);
        ser_strobe = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] w);
        shift_word(w);
        pulse_strobe();
        model(w);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset state");

        // R7: gain word with nothing selected after reset
        send(8'b0110_1111);
        check("R7 gain with no band after reset");

        // full sweep: every band, every step, boost and cut
        for (int b = 1; b <= NB; b++) begin
            logic [7:0] bw;
            bw = {1'b1, b[0], b[1], b[2], b[3:0]};
            send(bw);
            check("R4 R10 band select");
            for (int db = 0; db <= 12; db++) begin
                for (int bst = 0; bst < 2; bst++) begin
                    send({1'b0, bst[0], gain_pat(db)});
                    if (db == 0) check("R6 flat ignores boost bit");
                    else         check("R5 R8 R2 gain update");
                end
            end
            // leave a distinct setting behind in this band
            send({1'b0, b[0], gain_pat((b % 12) + 1)});
            check("R5 R9 band retains gain");
        end

        // R7: codes 0 and 15 select nothing
        send(8'b1000_0000);
        send(8'b0100_0001);
        check("R7 code 0 gain ignored");
        send(8'b1111_1111);
        check("R4 code 15 select with both half ranges");
        send(8'b0011_1111);
        check("R7 code 15 gain ignored");

        // R3: shift without strobe changes nothing, strobe alone applies it
        send(8'b1000_0011);
        check("R4 select band 3");
        shift_word(8'b0110_1001);
        check("R3 no strobe no change");
        pulse_strobe();
        model(8'b0110_1001);
        check("R3 strobe applies held word");

        // R2: asymmetric pattern on a channel B band
        send(8'b1000_1110);
        send(8'b0000_0110);
        check("R2 bit order cut on band 14");
        send(8'b0100_1100);
        check("R8 selection kept for second gain word");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule